// File: doc/BRIEF.md
# Stopped-Clock Wake Controller

This block runs beside an interrupt controller and looks after the interrupt lines while the core's clocks are stopped. When the core announces entry into a low-power state with a one-cycle sleep strobe, the block takes a snapshot of the lines that could wake it. A line is in the snapshot only when it is enabled and its priority would let it be serviced at once. While the core sleeps, the block watches only those lines and raises a wake request on the first occurrence. Wake-up is driven by events alone, so the core never has to wake on a timer to poll.

Detection is level-sensitive and is held in a pending register, so a pulse one cycle long is not lost. The wake request stays high until the core acknowledges it. The acknowledge clears the snapshot and the pending bits. The controller has three states. `ST_AWAKE` goes to `ST_ASLEEP` on the sleep strobe (capture). `ST_ASLEEP` goes to `ST_WAKING` once any pending bit is set (detect). A sleep strobe in `ST_ASLEEP` recaptures the snapshot and keeps the state. `ST_WAKING` goes to `ST_AWAKE` on the acknowledge (release).

Top module: `stopclk_waker`

## Requirements
- R1: After reset, `wake_req` is 0 and `wake_mask` is all zeros.
- R2: A `sleep_enter` pulse in the awake state sets `wake_mask[i]` to `irq_en[i]` AND (priority of line i < `run_prio`) from the next clock edge. The priority of line i is `irq_prio[i*P +: P]`.
- R3: The priority comparison is strict. A line whose priority equals `run_prio` is left out of the mask.
- R4: A masked line sampled high at a clock edge while asleep makes `wake_req` rise at the second clock edge after that one. `wake_req` is still 0 after the first edge.
- R5: A masked line that is high for a single cycle keeps `wake_req` asserted after the line returns low.
- R6: While asleep, activity on lines outside the mask leaves `wake_req` at 0.
- R7: `wake_req` stays high until `wake_ack` is sampled high. After that edge, `wake_req` is 0 and `wake_mask` is zero.
- R8: A `sleep_enter` pulse while asleep recaptures `wake_mask` from the current enables, priorities and threshold.
- R9: While awake, the interrupt lines never raise `wake_req`.
- R10: While asleep, changes to `irq_en`, `irq_prio` or `run_prio` without a sleep strobe leave `wake_mask` unchanged.
- R11: `sleep_enter` while `wake_req` is high is ignored, so the mask and request are kept. `wake_ack` while asleep without a request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_en | input | N | Per-line enable |
| irq_prio | input | N*P | Per-line priority, line i at bits [i*P +: P]; lower value is more urgent |
| run_prio | input | P | Current execution priority threshold |
| irq_line | input | N | Raw interrupt lines, active high |
| sleep_enter | input | 1 | One-cycle strobe: core enters stopped-clock mode |
| wake_ack | input | 1 | Core acknowledges the wake request |
| wake_req | output | 1 | Wake request to the core |
| wake_mask | output | N | Captured wake mask |

## Verification
The bench aims at the strict priority boundary. A design that compares with less-or-equal would let an equal-priority line wake the core. It also tests one-cycle pulses that end before the request rises. A design that passes the line straight through without latching would drop the request. It changes the enables and the threshold in mid-sleep without a strobe, which would move a mask that was not truly snapshotted. It sends a sleep strobe while a request is outstanding, which a careless design would treat as a fresh capture and so bury the wake.

// File: rtl/wk_pkg.sv
package wk_pkg;
    typedef enum logic [1:0] {
        ST_AWAKE  = 2'd0,
        ST_ASLEEP = 2'd1,
        ST_WAKING = 2'd2
    } wk_state_e;
endpackage

// File: rtl/wk_eligible.sv
module wk_eligible #(
    parameter int N = 4,
    parameter int P = 3
) (
    input  logic [N-1:0]   en,
    input  logic [N*P-1:0] prio,
    input  logic [P-1:0]   thresh,
    output logic [N-1:0]   elig
);
    // R2/R3: enabled and strictly more urgent than the running level
    for (genvar i = 0; i < N; i++) begin : g_line
        assign elig[i] = en[i] && (prio[i*P +: P] < thresh);
    end
endmodule

// File: rtl/wk_pend.sv
module wk_pend #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         watch,
    input  logic         clr,
    input  logic [N-1:0] hit,
    output logic [N-1:0] pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pend <= '0;
        else if (clr)    pend <= '0;
        else if (watch)  pend <= pend | hit;
    end

    // Pending bits only accumulate until cleared
    p_pend_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((pend & $past(pend)) == $past(pend)));

    p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pend == '0));
endmodule

// File: rtl/stopclk_waker.sv
module stopclk_waker
    import wk_pkg::*;
#(
    parameter int N = 4,
    parameter int P = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   irq_en,
    input  logic [N*P-1:0] irq_prio,
    input  logic [P-1:0]   run_prio,
    input  logic [N-1:0]   irq_line,
    input  logic           sleep_enter,
    input  logic           wake_ack,
    output logic           wake_req,
    output logic [N-1:0]   wake_mask
);
    wk_state_e    state_q, state_d;
    logic [N-1:0] elig;
    logic [N-1:0] mask_q;
    logic [N-1:0] pend;
    logic         capture;
    logic         release_go;
    logic         watching;

    wk_eligible #(.N(N), .P(P)) u_elig (
        .en    (irq_en),
        .prio  (irq_prio),
        .thresh(run_prio),
        .elig  (elig)
    );

    assign capture    = sleep_enter && (state_q != ST_WAKING);
    assign release_go = wake_ack && (state_q == ST_WAKING);
    assign watching   = (state_q != ST_AWAKE);

    wk_pend #(.N(N)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .watch(watching),
        .clr  (release_go),
        .hit  (irq_line & mask_q),
        .pend (pend)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAKE:  if (sleep_enter) state_d = ST_ASLEEP;
            ST_ASLEEP: if (|pend)       state_d = ST_WAKING;
            ST_WAKING: if (wake_ack)    state_d = ST_AWAKE;
            default:                    state_d = ST_AWAKE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_AWAKE;
        else        state_q <= state_d;
    end

    // Snapshot register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          mask_q <= '0;
        else if (release_go) mask_q <= '0;
        else if (capture)    mask_q <= elig;
    end

    // Outputs
    always_comb begin
        wake_req  = (state_q == ST_WAKING);
        wake_mask = mask_q;
    end

    p_mask_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (wake_mask == $past(elig)));

    p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASLEEP && !sleep_enter) |=> $stable(wake_mask));

    p_rise_from_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> $past(|pend));

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !wake_ack) |=> wake_req);

    p_ack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && wake_ack) |=> (!wake_req && wake_mask == '0));

    p_ignore_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && sleep_enter && !wake_ack) |=> $stable(wake_mask));
endmodule

// File: tb/test_stopclk_waker.sv
module test_stopclk_waker;
    localparam int N = 4;
    localparam int P = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   irq_en = '0;
    logic [N*P-1:0] irq_prio = '0;
    logic [P-1:0]   run_prio = '0;
    logic [N-1:0]   irq_line = '0;
    logic           sleep_enter = 1'b0;
    logic           wake_ack = 1'b0;
    logic           wake_req;
    logic [N-1:0]   wake_mask;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    stopclk_waker #(.N(N), .P(P)) i_stopclk_waker (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .irq_prio(irq_prio),
        .run_prio(run_prio), .irq_line(irq_line), .sleep_enter(sleep_enter),
        .wake_ack(wake_ack), .wake_req(wake_req), .wake_mask(wake_mask)
    );

    // {en[4], prio[12] (line3..line0), thresh[3], expected mask[4]}
    localparam logic [22:0] VEC [6] = '{
        {4'b1111, 12'b111_101_010_000, 3'd3, 4'b0011},
        {4'b1010, 12'b111_101_010_000, 3'd6, 4'b0010},
        {4'b1111, 12'b100_100_100_100, 3'd4, 4'b0000},
        {4'b1111, 12'b100_100_100_100, 3'd5, 4'b1111},
        {4'b0000, 12'b000_000_000_000, 3'd7, 4'b0000},
        {4'b1101, 12'b001_110_011_110, 3'd7, 4'b1101}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic go_sleep(logic [N-1:0] en, logic [N*P-1:0] pr, logic [P-1:0] th);
        irq_en = en; irq_prio = pr; run_prio = th;
        sleep_enter = 1'b1; step(); sleep_enter = 1'b0;
    endtask

    task automatic ack();
        wake_ack = 1'b1; step(); wake_ack = 1'b0;
    endtask

    task automatic force_wake();
        go_sleep(4'b0001, '0, 3'd1);
        irq_line = 4'b0001; step(); irq_line = '0; step();
        ack();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        step(); step();
        check("R1 wake_req", 32'(wake_req), 0);
        check("R1 wake_mask", 32'(wake_mask), 0);
        rst_n = 1'b1;
        step();

        foreach (VEC[k]) begin
            logic [N-1:0] exp_m, fire;
            exp_m = VEC[k][3:0];
            go_sleep(VEC[k][22:19], VEC[k][18:7], VEC[k][6:4]);
            check("R2/R3 captured mask", 32'(wake_mask), 32'(exp_m));
            // R6: lines outside the mask
            irq_line = ~exp_m; step(); step(); step(); irq_line = '0; step();
            check("R6 unmasked lines", 32'(wake_req), 0);
            if (exp_m != '0) begin
                fire = exp_m & (~exp_m + 1'b1);
                irq_line = fire; step(); irq_line = '0;
                check("R4 first edge", 32'(wake_req), 0);
                step();
                check("R4 second edge", 32'(wake_req), 1);
                step(); step(); step();
                check("R5 latched pulse", 32'(wake_req), 1);
                ack();
                check("R7 req cleared", 32'(wake_req), 0);
                check("R7 mask cleared", 32'(wake_mask), 0);
            end else begin
                force_wake();
            end
        end

        // R9: awake, lines active
        irq_en = '1; irq_prio = '0; run_prio = 3'd7;
        irq_line = '1; step(); step(); step(); step(); irq_line = '0; step();
        check("R9 awake no wake", 32'(wake_req), 0);

        // R8 and R10
        go_sleep(4'b1111, 12'b111_101_010_000, 3'd3);
        check("R2 mask before recapture", 32'(wake_mask), 32'h3);
        irq_en = '0; run_prio = 3'd0; step(); step();
        check("R10 mask kept", 32'(wake_mask), 32'h3);
        go_sleep(4'b1111, 12'b100_100_100_100, 3'd5);
        check("R8 recaptured mask", 32'(wake_mask), 32'hF);

        // R11: ack while asleep ignored
        ack();
        check("R11 ack asleep mask", 32'(wake_mask), 32'hF);
        check("R11 ack asleep req", 32'(wake_req), 0);
        irq_line = 4'b1000; step(); irq_line = '0; step();
        check("R4 wake after recapture", 32'(wake_req), 1);

        // R11: strobe during request ignored
        go_sleep(4'b0001, '0, 3'd1);
        check("R11 strobe mask kept", 32'(wake_mask), 32'hF);
        check("R11 strobe req kept", 32'(wake_req), 1);
        ack();
        check("R7 final release", 32'(wake_req), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule